// File: doc/BRIEF.md
# Serial EEPROM Bus Target

This block is the two-wire serial bus target side of a 2048-byte non-volatile store. The store is modelled as an on-chip array of eight 256-byte banks. SCL and SDA are oversampled on the system clock. The block answers when its 7-bit bus address has the form 1010bbb, where bbb selects the bank. It then takes a one-byte offset inside that bank. After that, the host either sends data bytes or turns the bus around with a repeated START and reads.

Data bytes from the host are collected in a 32-byte page buffer. They go into the array only after a STOP that follows a complete byte. An internal timer then runs a self-timed write cycle of a parameterised length. While that cycle runs, the block refuses to acknowledge its address, so the host can poll until the write is done. A write-protect input makes the block refuse every data byte, so the array cannot change. Reads return bytes from an 11-bit pointer that steps by one after each byte and wraps around the full array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A byte after START whose upper four bits are 1010 is acknowledged (SDA pulled low during the ninth clock). Bit 0 of that byte is the direction: 0 for write, 1 for read. A byte with any other upper nibble is not acknowledged, and the block ignores the bus until the next START.
- R2: In the write direction, bits 3..1 of the address byte become pointer bits 10..8. The next byte becomes pointer bits 7..0. Both bytes are acknowledged.
- R3: While wpIn is high, every data byte is left unacknowledged, the array keeps its contents, and no write cycle starts.
- R4: Data bytes received after the offset are written to the array at consecutive addresses. This happens only when a STOP follows a complete byte. All bytes of one transaction are written in a single write cycle.
- R5: Inside a page write, the low five pointer bits wrap within the 32-byte page. A byte past the 32nd replaces the earlier byte at the same offset.
- R6: After a committed page write, the block leaves its address unacknowledged for WRITE_CYCLES clock cycles, then acknowledges it again.
- R7: Random read: an offset write, then a repeated START and a read-direction address, returns the byte at that offset. A read-direction address leaves the pointer's bank bits unchanged.
- R8: Sequential read steps the 11-bit pointer after each byte. The pointer rolls over from 2047 to 0. A host NACK ends the read.
- R9: A START or STOP that comes after two or more bits of a data byte abandons the whole transaction. Nothing is written and no write cycle starts.
- R10: After reset, sdaPullDown is low and the block is not in a write cycle.
- R11: Behaviour is the same at two bus rates whose SCL phase lengths differ by four to one, down to eight system clocks per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| wpIn | input | 1 | Write protect; high refuses data bytes |
| sdaPullDown | output | 1 | Drives the open-drain data line low when high |

## Verification
A wrong internal state shows up as a bad ninth-clock answer or as wrong read data. A wrong byte counter or sync stage breaks an acknowledge, and the host sees it within one byte. A wrong pointer or page offset is silent when it happens. It surfaces as wrong bytes on the first read-back after the write cycle, roughly one transaction later. A stuck or early-ending write timer shows up as the wrong number of refused address polls after the STOP.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK
  } busState_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_WORD,
    BK_DATA
  } byteKind_t;

  // control -> datapath strobes, with the byte they refer to
  typedef struct packed {
    logic       clearBuf;
    logic       setBlock;
    logic       setWord;
    logic       bufWrite;
    logic       addrInc;
    logic       commit;
    logic [7:0] value;
  } dpStrobe_t;
endpackage

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic       busyIn,
  input  logic [7:0] rdByte,
  output dpStrobe_t  stb,
  output logic       sdaPullDown
);
  logic [SYNC_STAGES-1:0] sclMeta, sdaMeta;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclMeta <= '1;
      sdaMeta <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclMeta <= {sclMeta[SYNC_STAGES-2:0], sclIn};
      sdaMeta <= {sdaMeta[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclMeta[SYNC_STAGES-1];
      sdaPrev <= sdaMeta[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclMeta[SYNC_STAGES-1];
  assign sdaS     = sdaMeta[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t stateQ, stateD;
  byteKind_t kindQ, kindD;
  logic [3:0] cntQ, cntD;
  logic [7:0] shiftQ, shiftD, txQ, txD;
  logic readQ, readD, hostAckQ, hostAckD, pullQ, pullD;

  always_comb begin
    stateD   = stateQ;
    kindD    = kindQ;
    cntD     = cntQ;
    shiftD   = shiftQ;
    txD      = txQ;
    readD    = readQ;
    hostAckD = hostAckQ;
    pullD    = pullQ;
    stb      = '0;
    stb.value = shiftQ;
    if (startDet) begin
      stateD = ST_RX;
      kindD  = BK_DEV;
      cntD   = '0;
      pullD  = 1'b0;
      stb.clearBuf = 1'b1;
    end else if (stopDet) begin
      // a stop right after a whole byte has clocked in at most one bit
      stb.commit = (stateQ == ST_RX) && (kindQ == BK_DATA) && (cntQ <= 4'd1);
      stateD = ST_IDLE;
      pullD  = 1'b0;
    end else begin
      case (stateQ)
        ST_RX: begin
          if (sclRise && cntQ < 4'd8) begin
            shiftD = {shiftQ[6:0], sdaS};
            cntD   = cntQ + 4'd1;
          end else if (sclFall && cntQ == 4'd8) begin
            pullD  = 1'b1;
            stateD = ST_ACK;
            unique case (kindQ)
              BK_DEV: begin
                if (shiftQ[7:4] == DEV_PREFIX && !busyIn) begin
                  readD        = shiftQ[0];
                  stb.setBlock = !shiftQ[0];
                end else begin
                  pullD  = 1'b0;
                  stateD = ST_IDLE;
                end
              end
              BK_WORD: stb.setWord = 1'b1;
              default: begin
                if (wpIn) begin
                  pullD  = 1'b0;
                  stateD = ST_IDLE;
                end else begin
                  stb.bufWrite = 1'b1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntD = '0;
            if (kindQ == BK_DEV && readQ) begin
              stateD = ST_TX;
              txD    = rdByte;
              pullD  = ~rdByte[7];
            end else begin
              stateD = ST_RX;
              pullD  = 1'b0;
              kindD  = (kindQ == BK_DEV) ? BK_WORD : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (cntQ == 4'd7) begin
              pullD       = 1'b0;
              stateD      = ST_HACK;
              stb.addrInc = 1'b1;
            end else begin
              txD   = {txQ[6:0], 1'b0};
              pullD = ~txQ[6];
              cntD  = cntQ + 4'd1;
            end
          end
        end
        ST_HACK: begin
          if (sclRise) begin
            hostAckD = ~sdaS;
          end else if (sclFall) begin
            if (hostAckQ) begin
              stateD = ST_TX;
              cntD   = '0;
              txD    = rdByte;
              pullD  = ~rdByte[7];
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      kindQ    <= BK_DEV;
      cntQ     <= '0;
      shiftQ   <= '0;
      txQ      <= '0;
      readQ    <= 1'b0;
      hostAckQ <= 1'b0;
      pullQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      kindQ    <= kindD;
      cntQ     <= cntD;
      shiftQ   <= shiftD;
      txQ      <= txD;
      readQ    <= readD;
      hostAckQ <= hostAckD;
      pullQ    <= pullD;
    end
  end

  assign sdaPullDown = pullQ;

  AST_WP_NO_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |-> !wpIn); // R3
  AST_BUSY_NO_ADDR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK && kindQ == BK_DEV) |-> !busyIn); // R6
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> !sclS); // R1
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int BLOCK_CNT    = 8,
  parameter int BLOCK_BYTES  = 256,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  output logic       busy,
  output logic [7:0] rdByte
);
  localparam int MEM_BYTES = BLOCK_CNT * BLOCK_BYTES;
  localparam int ADDR_W    = $clog2(MEM_BYTES);
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int WORD_W    = $clog2(BLOCK_BYTES);
  localparam int BLK_W     = $clog2(BLOCK_CNT);
  localparam int PAGE_W    = ADDR_W - OFF_W;
  localparam int TMR_W     = $clog2(WRITE_CYCLES + 1);

  logic [ADDR_W-1:0]     addrQ;
  logic [PAGE_W-1:0]     pageQ;
  logic [PAGE_BYTES-1:0] maskQ;
  logic                  busyQ;
  logic [TMR_W-1:0]      tmrQ;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            mem [MEM_BYTES];
  logic [OFF_W-1:0]      walkIdx;
  logic                  memWe;

  assign walkIdx = tmrQ[OFF_W-1:0];
  assign memWe   = busyQ && (int'(tmrQ) < PAGE_BYTES) && maskQ[walkIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      pageQ <= '0;
      maskQ <= '0;
      busyQ <= 1'b0;
      tmrQ  <= '0;
    end else begin
      if (stb.setBlock) addrQ[ADDR_W-1 -: BLK_W] <= stb.value[BLK_W:1];
      if (stb.setWord)  addrQ[WORD_W-1:0] <= stb.value[WORD_W-1:0];
      if (stb.bufWrite) begin
        maskQ[addrQ[OFF_W-1:0]] <= 1'b1;
        addrQ[OFF_W-1:0]        <= addrQ[OFF_W-1:0] + 1'b1;
      end
      if (stb.addrInc) addrQ <= addrQ + 1'b1;
      if (stb.clearBuf && !busyQ) maskQ <= '0;
      if (stb.commit && !busyQ && |maskQ) begin
        busyQ <= 1'b1;
        tmrQ  <= '0;
        pageQ <= addrQ[ADDR_W-1:OFF_W];
      end
      if (busyQ) begin
        if (tmrQ == TMR_W'(WRITE_CYCLES - 1)) begin
          busyQ <= 1'b0;
          maskQ <= '0;
        end else begin
          tmrQ <= tmrQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWrite) pageBuf[addrQ[OFF_W-1:0]] <= stb.value;
    if (memWe) mem[{pageQ, walkIdx}] <= pageBuf[walkIdx];
  end

  assign rdByte = mem[addrQ];
  assign busy   = busyQ;

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |=> addrQ[ADDR_W-1:OFF_W] == $past(addrQ[ADDR_W-1:OFF_W])); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrInc |=> addrQ == $past(addrQ) + ADDR_W'(1)); // R8
  AST_COMMIT_STARTS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(stb.commit)); // R4
  AST_WRITE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(tmrQ) == TMR_W'(WRITE_CYCLES - 1)); // R6
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int         BLOCK_CNT    = 8,
  parameter int         BLOCK_BYTES  = 256,
  parameter int         PAGE_BYTES   = 32,
  parameter int         WRITE_CYCLES = 1000000,
  parameter logic [3:0] DEV_PREFIX   = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaPullDown
);
  dpStrobe_t  stb;
  logic       busy;
  logic [7:0] rdByte;

  eeprom_bus_ctrl #(
    .DEV_PREFIX (DEV_PREFIX),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .wpIn       (wpIn),
    .busyIn     (busy),
    .rdByte     (rdByte),
    .stb        (stb),
    .sdaPullDown(sdaPullDown)
  );

  eeprom_store #(
    .BLOCK_CNT   (BLOCK_CNT),
    .BLOCK_BYTES (BLOCK_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_store (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .busy  (busy),
    .rdByte(rdByte)
  );
endmodule

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_target_bench;
  localparam int WCYC = 2000;
  localparam int FAST = 8;
  localparam int SLOW = 32;
  // {half period, address, data}
  localparam logic [26:0] VEC [8] = '{
    {8'd8,  11'h010, 8'h3C}, {8'd32, 11'h1FF, 8'hC5},
    {8'd8,  11'h2A5, 8'h00}, {8'd32, 11'h300, 8'hFF},
    {8'd8,  11'h455, 8'h81}, {8'd32, 11'h5C3, 8'h7E},
    {8'd8,  11'h6EE, 8'h12}, {8'd32, 11'h7A0, 8'hE9}
  };

  logic clk = 1'b0, rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1, wp = 1'b0;
  logic pull;
  logic sdaBus;
  int halfP = FAST;
  int checks = 0, errors = 0;
  logic [7:0] dataBuf [40];
  logic [7:0] rdBuf [40];

  assign sdaBus = sdaDrv & ~pull;
  always #2.5 clk = ~clk;

  i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) u_i2c_eeprom_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .wpIn(wp), .sdaPullDown(pull)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(halfP); sclDrv = 1'b1; tick(halfP);
    sdaDrv = 1'b0; tick(halfP); sclDrv = 1'b0; tick(halfP);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(halfP); sclDrv = 1'b1; tick(halfP); sdaDrv = 1'b1; tick(halfP);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; tick(halfP); sclDrv = 1'b1; tick(halfP); sclDrv = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaDrv = 1'b1; tick(halfP); sclDrv = 1'b1; tick(halfP / 2);
    acked = (sdaBus == 1'b0);
    tick(halfP - halfP / 2); sclDrv = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(halfP); sclDrv = 1'b1; tick(halfP / 2); b[i] = sdaBus;
      tick(halfP - halfP / 2); sclDrv = 1'b0;
    end
    sdaDrv = !ackIt; tick(halfP); sclDrv = 1'b1; tick(halfP); sclDrv = 1'b0;
  endtask

  task automatic pageWrite(input logic [10:0] a, input int n, output logic devOk, output logic dataOk);
    logic ak;
    busStart();
    sendByte({4'hA, a[10:8], 1'b0}, devOk);
    dataOk = 1'b0;
    if (devOk) begin
      sendByte(a[7:0], ak);
      dataOk = ak;
      for (int i = 0; i < n; i++) begin
        sendByte(dataBuf[i], ak);
        if (!ak) begin dataOk = 1'b0; break; end
      end
    end
    busStop();
  endtask

  task automatic pollReady(output int polls);
    logic ak;
    polls = 0;
    do begin
      busStart(); sendByte(8'hA0, ak); busStop(); polls++;
    end while (!ak && polls < 200);
  endtask

  task automatic randomRead(input logic [10:0] a, input int n, output logic ok);
    logic a1, a2, a3;
    busStart();
    sendByte({4'hA, a[10:8], 1'b0}, a1);
    sendByte(a[7:0], a2);
    busStart();
    sendByte(8'hA1, a3);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    busStop();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ok, ok2;
    int polls;
    tick(10);
    rstN = 1'b1;
    tick(4);
    check("R10", "pull-down after reset", pull, 0);
    busStart(); sendByte(8'hA0, ok); busStop();
    check("R10", "address ack right after reset (no write cycle)", ok, 1);
    busStart(); sendByte(8'hB0, ok); busStop();
    check("R1", "foreign prefix left unacknowledged", ok, 0);

    // table walk: single-byte writes then random reads, two bus rates
    for (int v = 0; v < 8; v++) begin
      halfP = int'(VEC[v][26:19]);
      dataBuf[0] = VEC[v][7:0];
      pageWrite(VEC[v][18:8], 1, ok, ok2);
      check("R1", "device address ack", ok, 1);
      check("R2", "offset and data ack", ok2, 1);
      pollReady(polls);
      check("R6", "first poll refused during write cycle", int'(polls > 1), 1);
      check("R6", "write cycle ends", int'(polls < 200), 1);
      randomRead(VEC[v][18:8], 1, ok);
      check("R7", "random read acks", ok, 1);
      check(halfP == SLOW ? "R11" : "R4", "read-back byte", rdBuf[0], VEC[v][7:0]);
    end
    halfP = FAST;

    // page overrun: 34 bytes from offset 0
    for (int i = 0; i < 34; i++) dataBuf[i] = 8'(8'h40 + i);
    pageWrite(11'h200, 34, ok, ok2);
    check("R4", "34-byte page accepted", ok2, 1);
    pollReady(polls);
    randomRead(11'h200, 32, ok);
    for (int i = 0; i < 32; i++)
      check("R5", "page overrun content", rdBuf[i], (i < 2) ? 8'h60 + i : 8'h40 + i);

    // offset wrap inside page starting at offset 28
    for (int i = 0; i < 6; i++) dataBuf[i] = 8'(8'h90 + i);
    pageWrite(11'h13C, 6, ok, ok2);
    pollReady(polls);
    randomRead(11'h13C, 4, ok);
    for (int i = 0; i < 4; i++) check("R5", "page tail bytes", rdBuf[i], 8'h90 + i);
    randomRead(11'h120, 2, ok);
    check("R5", "wrapped byte at offset 0", rdBuf[0], 8'h94);
    check("R5", "wrapped byte at offset 1", rdBuf[1], 8'h95);

    // sequential rollover and current-address read
    dataBuf[0] = 8'hA1; dataBuf[1] = 8'hA2;
    pageWrite(11'h7FE, 2, ok, ok2);
    pollReady(polls);
    dataBuf[0] = 8'hA3; dataBuf[1] = 8'hA4;
    pageWrite(11'h000, 2, ok, ok2);
    pollReady(polls);
    randomRead(11'h7FE, 3, ok);
    check("R8", "byte 2046", rdBuf[0], 8'hA1);
    check("R8", "byte 2047", rdBuf[1], 8'hA2);
    check("R8", "rollover to byte 0", rdBuf[2], 8'hA3);
    busStart(); sendByte(8'hAF, ok); recvByte(1'b0, rdBuf[0]); busStop();
    check("R7", "read address bank bits ignored, pointer at 1", rdBuf[0], 8'hA4);

    // write protect
    wp = 1'b1;
    dataBuf[0] = 8'h5A;
    pageWrite(11'h010, 1, ok, ok2);
    check("R3", "address acked under protect", ok, 1);
    check("R3", "data byte refused under protect", ok2, 0);
    wp = 1'b0;
    pollReady(polls);
    check("R3", "no write cycle under protect", polls, 1);
    randomRead(11'h010, 1, ok);
    check("R3", "protected byte unchanged", rdBuf[0], 8'h3C);

    // STOP after a partial data byte
    busStart(); sendByte(8'hA0, ok); sendByte(8'h10, ok); sendByte(8'h11, ok);
    sendBits(8'h22, 3); busStop();
    pollReady(polls);
    check("R9", "no write cycle after mid-byte stop", polls, 1);
    randomRead(11'h010, 1, ok);
    check("R9", "byte unchanged after mid-byte stop", rdBuf[0], 8'h3C);

    // START after a partial data byte
    busStart(); sendByte(8'hA2, ok); sendByte(8'hFF, ok); sendBits(8'h66, 4);
    busStart(); sendByte(8'hA0, ok); busStop();
    pollReady(polls);
    check("R9", "no write cycle after mid-byte start", polls, 1);
    randomRead(11'h1FF, 1, ok);
    check("R9", "byte unchanged after mid-byte start", rdBuf[0], 8'hC5);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule